// File: doc/BRIEF.md
# Reduced-Pin Ethernet Receive Adapter

This block sits on the MAC side of a reduced-pin Ethernet receive link. It runs from the single 50 MHz reference clock that the transmit and receive paths share. It samples a two-bit receive bus, a line that carries both carrier and data-valid information, and a receive error line. It does four things:

- It splits the combined line into a separate carrier-sense flag and a data-valid flag.
- It skips the alternating preamble and locates the start of the frame.
- It packs the two-bit groups (dibbles) into bytes.
- It produces a byte stream with one-cycle valid, error, start and end strobes.

A speed input selects the mode. At 100 Mbps one dibble arrives on every clock. At 10 Mbps the physical layer holds each dibble for ten clocks, and the adapter samples it once in that window. When the carrier drops while the physical layer is still draining queued data, the combined line alternates within each nibble. The adapter keeps the frame open in that case but reports the carrier as gone.

Top module: `rmii_rx_adapter`

## Requirements
- R1: With `fastMode` high, one dibble is sampled on every rising clock edge.
- R2: With `fastMode` low, one dibble is sampled every tenth edge. The first sample is on the first edge after reset is released. Values on the bus, the combined line and the error line during the other nine edges have no effect.
- R3: Preamble handling:
  - While the frame has not started, all-zero dibbles with the combined line high are ignored.
  - A preamble dibble is 2'b01, meaning bit 0 is 1 and bit 1 is 0.
  - The frame starts at the first 2'b11 dibble that follows at least one 2'b01 dibble, with the combined line high throughout.
  - A 2'b11 or 2'b10 dibble with no 2'b01 before it does not start a frame.
- R4: Start of frame gives a one-cycle `sofStrobe` on the edge that samples the 2'b11 dibble, and `dvOut` rises on the same edge.
- R5: Byte assembly:
  - The four dibbles after the start form one byte, and the first dibble received lands in bits [1:0].
  - `byteValid` pulses for one cycle after the edge that samples the fourth dibble.
  - `dvOut` is high whenever `byteValid` is high.
- R6: `byteErr` is high with a byte exactly when `rxErrIn` was high on at least one of its four sampled dibbles. The error line has no effect outside a frame.
- R7: End of frame:
  - A nibble is two dibbles, counted from the start of frame.
  - When the combined line is low on both dibbles of one nibble, `eofStrobe` pulses for one cycle and `dvOut` falls.
  - The dibbles of that nibble, and any incomplete byte, are discarded.
- R8: Draining after carrier loss:
  - In a frame, a nibble with the combined line low on its first dibble and high on its second keeps `dvOut` high.
  - Its data is still assembled.
  - `crsOut` goes low.
- R9: `crsOut` behaves differently inside and outside a frame:
  - Outside a frame, it follows the combined line at every sample.
  - Inside a frame, it takes the combined line's value only on the first dibble of each nibble.
- R10: A synchronous active-high `rst` clears the divider, the preamble search, the byte assembly and all outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared 50 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| fastMode | input | 1 | 1 selects 100 Mbps, 0 selects 10 Mbps |
| rxDibble | input | 2 | Receive data bus, bit 0 first on the wire |
| crsDvIn | input | 1 | Combined carrier / data-valid line |
| rxErrIn | input | 1 | Receive error line |
| crsOut | output | 1 | Recovered carrier sense |
| dvOut | output | 1 | Recovered data valid, high from start to end of frame |
| byteOut | output | 8 | Assembled byte, valid while `byteValid` is high |
| byteValid | output | 1 | One-cycle strobe for `byteOut` |
| byteErr | output | 1 | Error flag for the byte in `byteOut` |
| sofStrobe | output | 1 | One-cycle start-of-frame strobe |
| eofStrobe | output | 1 | One-cycle end-of-frame strobe |

## Verification
The bench runs the following input patterns:

- **All 256 byte values in one frame at full rate.** This separates correct dibble order from swapped or reversed packing.
- **Short frames of one to six bytes.** These use every mix of draining tail, trailing half byte and a false delimiter before the preamble. They tell apart:
  - a frame end that keeps the frame open during the alternating pattern;
  - one that closes it early;
  - one that emits a torn byte.
- **Ten-clock mode with inverted values on the nine unsampled clocks.** Any extra sampling corrupts the byte stream or multiplies the strobes.
- **Reset in the middle of a frame.** This shows that no stale half-byte or error bit leaks into the next frame.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  localparam int DIB_W = 2;

  typedef enum logic { ST_HUNT, ST_FRAME } rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic byteDone;
    logic clearAcc;
  } dpCtrl_t;
endpackage

// File: rtl/rmii_rx_ctrl.sv
module rmii_rx_ctrl
  import rmii_rx_pkg::*;
#(
  parameter int SLOW_DIV      = 10,
  parameter int DIBS_PER_BYTE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fastMode,
  input  logic [DIB_W-1:0] rxDibble,
  input  logic             crsDvIn,
  output dpCtrl_t          dpCtrl,
  output logic             crsOut,
  output logic             dvOut,
  output logic             sofStrobe,
  output logic             eofStrobe
);
  localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int IDX_W = (DIBS_PER_BYTE > 1) ? $clog2(DIBS_PER_BYTE) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DIBS_PER_BYTE - 1);

  logic [DIV_W-1:0] divCnt;
  logic             sampleEn;

  generate
    if (SLOW_DIV > 1) begin : g_div
      always_ff @(posedge clk) begin
        if (rst || divCnt == DIV_W'(SLOW_DIV - 1)) divCnt <= '0;
        else                                       divCnt <= divCnt + 1'b1;
      end
    end else begin : g_nodiv
      assign divCnt = '0;
    end
  endgenerate

  assign sampleEn = fastMode || (divCnt == '0);

  rxState_t         state;
  logic             seenPre;
  logic             firstLow;
  logic [IDX_W-1:0] dibIdx;

  logic hunting, firstDib, sofNow, eofNow, shiftNow, byteNow;

  always_comb begin
    hunting  = (state == ST_HUNT);
    firstDib = ~dibIdx[0];
    sofNow   = sampleEn && hunting && crsDvIn && (rxDibble == 2'b11) && seenPre;
    eofNow   = sampleEn && !hunting && !firstDib && !crsDvIn && firstLow;
    shiftNow = sampleEn && !hunting && !eofNow;
    byteNow  = shiftNow && (dibIdx == LAST_IDX);
  end

  assign dpCtrl = '{shiftEn: shiftNow, byteDone: byteNow, clearAcc: sofNow};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HUNT;
      seenPre   <= 1'b0;
      firstLow  <= 1'b0;
      dibIdx    <= '0;
      crsOut    <= 1'b0;
      dvOut     <= 1'b0;
      sofStrobe <= 1'b0;
      eofStrobe <= 1'b0;
    end else begin
      sofStrobe <= sofNow;
      eofStrobe <= eofNow;
      if (sampleEn) begin
        if (hunting) begin
          crsOut <= crsDvIn;
          if (sofNow) begin
            state   <= ST_FRAME;
            dvOut   <= 1'b1;
            dibIdx  <= '0;
            seenPre <= 1'b0;
          end else if (!crsDvIn) begin
            seenPre <= 1'b0;
          end else if (rxDibble == 2'b01) begin
            seenPre <= 1'b1;
          end else if (rxDibble != 2'b00) begin
            seenPre <= 1'b0;
          end
        end else begin
          if (firstDib) begin
            crsOut   <= crsDvIn;
            firstLow <= !crsDvIn;
          end
          if (eofNow) begin
            state  <= ST_HUNT;
            dvOut  <= 1'b0;
            crsOut <= 1'b0;
            dibIdx <= '0;
          end else begin
            dibIdx <= byteNow ? '0 : dibIdx + 1'b1;
          end
        end
      end
    end
  end

  AST_SLOW_SPACING: assert property (@(posedge clk) disable iff (rst)
    (!fastMode && $past(!fastMode) && !$past(rst) && sampleEn) |-> !$past(sampleEn)); // R2
  AST_SOF_OPENS_DV: assert property (@(posedge clk) disable iff (rst)
    sofStrobe |-> dvOut); // R4
  AST_EOF_CLOSES: assert property (@(posedge clk) disable iff (rst)
    eofStrobe |-> (!dvOut && !crsOut)); // R7
endmodule

// File: rtl/rmii_rx_dp.sv
module rmii_rx_dp
  import rmii_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           dpCtrl,
  input  logic [DIB_W-1:0]  rxDibble,
  input  logic              rxErrIn,
  output logic [BYTE_W-1:0] byteOut,
  output logic              byteValid,
  output logic              byteErr
);
  logic [BYTE_W-1:0] acc;
  logic [BYTE_W-1:0] nextAcc;
  logic              errAcc;

  assign nextAcc = {rxDibble, acc[BYTE_W-1:DIB_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      errAcc    <= 1'b0;
      byteOut   <= '0;
      byteValid <= 1'b0;
      byteErr   <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      byteErr   <= 1'b0;
      if (dpCtrl.clearAcc) begin
        acc    <= '0;
        errAcc <= 1'b0;
      end else if (dpCtrl.shiftEn) begin
        if (dpCtrl.byteDone) begin
          byteOut   <= nextAcc;
          byteValid <= 1'b1;
          byteErr   <= errAcc | rxErrIn;
          errAcc    <= 1'b0;
        end else begin
          errAcc <= errAcc | rxErrIn;
        end
        acc <= nextAcc;
      end
    end
  end

  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    byteErr |-> byteValid); // R6
  AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (byteValid && $past(!dpCtrl.byteDone)) |-> 1'b0); // R5
endmodule

// File: rtl/rmii_rx_adapter.sv
module rmii_rx_adapter
  import rmii_rx_pkg::*;
#(
  parameter int SLOW_DIV = 10,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fastMode,
  input  logic [1:0]        rxDibble,
  input  logic              crsDvIn,
  input  logic              rxErrIn,
  output logic              crsOut,
  output logic              dvOut,
  output logic [BYTE_W-1:0] byteOut,
  output logic              byteValid,
  output logic              byteErr,
  output logic              sofStrobe,
  output logic              eofStrobe
);
  localparam int DIBS_PER_BYTE = BYTE_W / DIB_W;

  dpCtrl_t dpCtrl;

  rmii_rx_ctrl #(.SLOW_DIV(SLOW_DIV), .DIBS_PER_BYTE(DIBS_PER_BYTE)) u_ctrl (
    .clk(clk), .rst(rst), .fastMode(fastMode), .rxDibble(rxDibble),
    .crsDvIn(crsDvIn), .dpCtrl(dpCtrl), .crsOut(crsOut), .dvOut(dvOut),
    .sofStrobe(sofStrobe), .eofStrobe(eofStrobe)
  );

  rmii_rx_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst(rst), .dpCtrl(dpCtrl), .rxDibble(rxDibble),
    .rxErrIn(rxErrIn), .byteOut(byteOut), .byteValid(byteValid),
    .byteErr(byteErr)
  );

  AST_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    byteValid |-> dvOut); // R5
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!byteValid && !sofStrobe && !eofStrobe && !dvOut && !crsOut)); // R10
endmodule

// File: tb/sim_rmii_rx_adapter.sv
module sim_rmii_rx_adapter;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fastMode = 1'b1;
  logic [1:0] rxDibble = 2'b00;
  logic crsDvIn = 1'b0;
  logic rxErrIn = 1'b0;
  logic crsOut, dvOut, byteValid, byteErr, sofStrobe, eofStrobe;
  logic [7:0] byteOut;

  int checks = 0;
  int errors = 0;
  int gotN = 0, sofCnt = 0, eofCnt = 0;
  logic [7:0] gotByte [MAXB];
  logic       gotErr  [MAXB];

  rmii_rx_adapter u0 (
    .clk(clk), .rst(rst), .fastMode(fastMode), .rxDibble(rxDibble),
    .crsDvIn(crsDvIn), .rxErrIn(rxErrIn), .crsOut(crsOut), .dvOut(dvOut),
    .byteOut(byteOut), .byteValid(byteValid), .byteErr(byteErr),
    .sofStrobe(sofStrobe), .eofStrobe(eofStrobe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always begin
    @(posedge clk);
    #2;
    if (byteValid) begin
      if (gotN < MAXB) begin
        gotByte[gotN] = byteOut;
        gotErr[gotN]  = byteErr;
      end
      gotN++;
    end
    if (sofStrobe) sofCnt++;
    if (eofStrobe) eofCnt++;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int seed, input int i);
    return 8'(i * 29 + seed);
  endfunction

  // called at a negedge, returns at a negedge after one sample window
  task automatic sendDib(input logic [1:0] d, input logic crs, input logic err);
    rxDibble = d; crsDvIn = crs; rxErrIn = err;
    @(negedge clk);
    if (!fastMode) begin
      rxDibble = ~d; crsDvIn = ~crs; rxErrIn = ~err;
      repeat (9) @(negedge clk);
    end
  endtask

  task automatic doReset(input logic fast);
    rst = 1'b1; fastMode = fast;
    rxDibble = 2'b00; crsDvIn = 1'b0; rxErrIn = 1'b0;
    repeat (3) @(negedge clk);
    chk(!dvOut && !crsOut && !byteValid && !sofStrobe && !eofStrobe,
        "R10 outputs cleared in reset", int'({dvOut, crsOut, byteValid, sofStrobe, eofStrobe}), 0);
    rst = 1'b0;
  endtask

  task automatic runFrame(input int nBytes, input int seed, input int errIdx,
                          input int drainBytes, input int tailDibs, input bit bogusLead);
    logic [7:0] b;
    bit drain;
    bit drainSeen;
    gotN = 0; sofCnt = 0; eofCnt = 0;
    drainSeen = 1'b0;
    repeat (3) sendDib(2'b00, 1'b1, 1'b0);
    chk(crsOut == 1'b1, "R9 carrier follows line outside frame", int'(crsOut), 1);
    chk(dvOut == 1'b0 && sofCnt == 0, "R3 zero dibbles do not start a frame", sofCnt, 0);
    if (bogusLead) begin
      sendDib(2'b11, 1'b1, 1'b0);
      sendDib(2'b10, 1'b1, 1'b0);
      chk(sofCnt == 0 && dvOut == 1'b0, "R3 delimiter without preamble ignored", sofCnt, 0);
    end
    for (int k = 0; k < 5; k++) sendDib(2'b01, 1'b1, k == 1);
    sendDib(2'b11, 1'b1, 1'b0);
    chk(sofCnt == 1 && dvOut == 1'b1, "R4 start strobe and data valid", sofCnt, 1);
    for (int i = 0; i < nBytes; i++) begin
      b = bval(seed, i);
      drain = (i >= nBytes - drainBytes);
      for (int k = 0; k < 4; k++) begin
        sendDib(b[2*k +: 2], drain ? (k % 2 == 1) : 1'b1, (i == errIdx) && (k == 2));
        if (drain && !drainSeen && k == 0) begin
          drainSeen = 1'b1;
          chk(crsOut == 1'b0 && dvOut == 1'b1, "R8 drain keeps valid, drops carrier",
              int'({crsOut, dvOut}), 1);
        end
      end
    end
    for (int k = 0; k < tailDibs; k++) sendDib(2'(k + 1), 1'b1, 1'b0);
    sendDib(2'b00, 1'b0, 1'b0);
    sendDib(2'b00, 1'b0, 1'b0);
    chk(eofCnt == 1 && dvOut == 1'b0, "R7 end strobe once and valid low", eofCnt, 1);
    chk(sofCnt == 1, "R4 single start strobe per frame", sofCnt, 1);
    sendDib(2'b00, 1'b0, 1'b1);
    sendDib(2'b00, 1'b0, 1'b0);
    chk(crsOut == 1'b0, "R9 carrier low after frame", int'(crsOut), 0);
    chk(gotN == nBytes, fastMode ? "R1 byte count" : "R2 byte count", gotN, nBytes);
    for (int i = 0; i < nBytes && i < MAXB && i < gotN; i++) begin
      chk(gotByte[i] == bval(seed, i), "R5 byte value", int'(gotByte[i]), int'(bval(seed, i)));
      chk(gotErr[i] == (i == errIdx), "R6 byte error flag", int'(gotErr[i]), int'(i == errIdx));
    end
  endtask

  initial begin
    @(negedge clk);
    doReset(1'b1);
    runFrame(256, 0, 17, 0, 0, 1'b0);
    for (int n = 1; n <= 6; n++) begin
      runFrame(n, n * 7, n - 1, n % 3, (n % 2) * 2, n[1]);
    end
    runFrame(3, 99, -1, 3, 2, 1'b1);

    doReset(1'b0);
    runFrame(12, 3, 4, 2, 2, 1'b1);
    runFrame(1, 200, 0, 1, 0, 1'b0);
    runFrame(5, 41, -1, 0, 2, 1'b0);

    // reset in the middle of a frame, then a clean frame
    for (int s = 0; s < 2; s++) begin
      logic fast;
      fast = (s == 0);
      doReset(fast);
      for (int k = 0; k < 3; k++) sendDib(2'b01, 1'b1, 1'b0);
      sendDib(2'b11, 1'b1, 1'b0);
      sendDib(2'b10, 1'b1, 1'b1);
      sendDib(2'b01, 1'b1, 1'b0);
      rst = 1'b1;
      @(negedge clk);
      chk(!dvOut && !byteValid && !crsOut, "R10 mid-frame reset clears",
          int'({dvOut, byteValid, crsOut}), 0);
      doReset(fast);
      runFrame(4, 60 + s, -1, 0, 0, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule